// File: doc/BRIEF.md
# Card Clock Divider with Bus Configuration

This block derives the clock for a memory card interface from the master clock. A programmable divider makes a card clock of master/(2·N) with equal high and low phases. A zero divider value passes the master clock straight through, except in double-data-rate timing. There, a zero is raised to a divide-by-two, because a clock passed straight through cannot serve double-rate sampling. A separate request flag for a zero target rate selects the slowest setting, the largest divider value, and the clock keeps running.

Next to the clock, the block registers the bus settings the card interface needs: two data-width flags, a double-rate enable, a high-speed flag, a hardware flow-control enable that is always set, and a pass-through select for a feedback sampling clock. The timing mode code drives the double-rate and high-speed flags. All settings, the divider included, are taken up together and only at a rising edge of the card clock, so a change never makes a runt pulse. A one-cycle enable strobe marks each rising edge for logic that runs in the master domain.

Top module: `card_clk_div`

## Requirements
- R1: With a nonzero divider N and no zero-rate request, `ck_en_o` pulses for one master cycle every 2·N master cycles.
- R2: With divider 0 in a non-double-rate mode, `bypass_o` is 1, `ck_o` follows the master clock (high while `clk_i` is high) and `ck_en_o` is 1 in every cycle.
- R3: With divider 0 and mode code 2 (double-rate), the block does not bypass: `bypass_o` is 0 and the strobe period is 2 master cycles.
- R4: When `rate_zero_i` is 1, the divider in use is 2^DIV_W−1 whatever `div_i` holds, so the strobe period is 2·(2^DIV_W−1) cycles.
- R5: Width code 0 gives 1-bit (both flags 0), code 1 sets only `wide4_o`, code 2 sets only `wide8_o`, and code 3 is taken as 1-bit.
- R6: Outside bypass, `ck_o` is high for N master cycles, starting in the cycle of the strobe, and then low for N cycles.
- R7: `ddr_o` is 1 only for mode code 2. `speed_o` is 1 for mode codes 3 and above (codes 0 to 2 clear it). `hwfc_o` is 1 once the first setting has been taken up.
- R8: Changes on the setting inputs take effect only in the cycle of a `ck_en_o` pulse. Between pulses, every registered output keeps its value.
- R9: While `rst_ni` is low, `ck_o`, `ck_en_o` and all setting outputs are 0. The first settings are taken up in the first cycle after reset.
- R10: `fb_sel_o` takes the value of `fb_sel_i` at each rising edge of the card clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| div_i | input | DIV_W | Divider value N (0 selects bypass) |
| rate_zero_i | input | 1 | Zero target rate: use the largest divider |
| mode_i | input | 3 | Timing mode: 0 legacy, 1 high-speed, 2 double-rate, 3 SDR50, 4+ SDR104 |
| width_i | input | 2 | Data width code: 0 1-bit, 1 4-bit, 2 8-bit |
| fb_sel_i | input | 1 | Feedback clock selection request |
| ck_o | output | 1 | Card clock |
| ck_en_o | output | 1 | Strobe marking a card clock rising edge |
| bypass_o | output | 1 | Master clock passed through |
| wide4_o | output | 1 | 4-bit bus selected |
| wide8_o | output | 1 | 8-bit bus selected |
| ddr_o | output | 1 | Double-rate enable |
| speed_o | output | 1 | High bus speed flag |
| hwfc_o | output | 1 | Hardware flow control enable |
| fb_sel_o | output | 1 | Feedback clock selection, applied |

## Verification
The assertions assume that the setting inputs change only between master clock edges and that the reset is held for at least one edge. The stimulus drives every input on the falling edge, and the bench aligns itself to strobe pulses before it measures a period. Changes in the middle of a card clock period are made on purpose, one cycle after a strobe, so that the deferred take-up is observed rather than assumed. The zero-rate case is run with the default divider width so that its long period stays inside the run.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    typedef enum logic [2:0] {
        MODE_LEGACY = 3'd0,
        MODE_HS     = 3'd1,
        MODE_DDR    = 3'd2,
        MODE_SDR50  = 3'd3,
        MODE_SDR104 = 3'd4
    } speed_mode_e;

    localparam logic [1:0] WIDTH_CODE_4 = 2'b01;
    localparam logic [1:0] WIDTH_CODE_8 = 2'b10;

    typedef struct packed {
        logic wide4;
        logic wide8;
        logic ddr;
        logic speed;
        logic hwfc;
        logic fbsel;
    } bus_cfg_t;

endpackage

// File: rtl/ccd_cfg_decode.sv
module ccd_cfg_decode
    import ccd_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic             rate_zero_i,
    input  logic [2:0]       mode_i,
    input  logic [1:0]       width_i,
    input  logic             fb_sel_i,
    output logic [DIV_W-1:0] half_o,
    output logic             byp_o,
    output bus_cfg_t         bus_o
);
    localparam logic [DIV_W-1:0] HALF_MAX = {DIV_W{1'b1}};
    localparam logic [DIV_W-1:0] HALF_ONE = DIV_W'(1);

    logic is_ddr;

    always_comb begin
        is_ddr = (mode_i == MODE_DDR);

        // divider choice: zero rate beats everything, then bypass rules
        half_o = div_i;
        byp_o  = 1'b0;
        if (rate_zero_i) begin
            half_o = HALF_MAX;
        end else if (div_i == '0) begin
            half_o = HALF_ONE;
            byp_o  = !is_ddr;
        end

        bus_o.wide4 = (width_i == WIDTH_CODE_4);
        bus_o.wide8 = (width_i == WIDTH_CODE_8);
        bus_o.ddr   = is_ddr;
        bus_o.speed = (mode_i >= MODE_SDR50);
        bus_o.hwfc  = 1'b1;
        bus_o.fbsel = fb_sel_i;
    end

endmodule

// File: rtl/ccd_toggle_core.sv
module ccd_toggle_core
    import ccd_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] new_half_i,
    input  logic             new_byp_i,
    input  bus_cfg_t         new_bus_i,
    output logic             ck_o,
    output logic             rise_o,
    output logic             byp_o,
    output bus_cfg_t         bus_o
);
    localparam logic [DIV_W-1:0] HALF_ONE = DIV_W'(1);

    typedef struct packed {
        logic             ck;
        logic             rise;
        logic             byp;
        logic             started;
        logic [DIV_W-1:0] cnt;
        logic [DIV_W-1:0] half;
        bus_cfg_t         bus;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     tick, take;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == st_q.half - HALF_ONE);
        // settings are taken up only where a rising edge begins
        take = !st_q.started || st_q.byp || (tick && !st_q.ck);

        if (take) begin
            st_d.started = 1'b1;
            st_d.half    = new_half_i;
            st_d.byp     = new_byp_i;
            st_d.bus     = new_bus_i;
            st_d.cnt     = '0;
            st_d.ck      = !new_byp_i;
            st_d.rise    = 1'b1;
        end else if (tick) begin
            st_d.ck   = 1'b0;
            st_d.cnt  = '0;
            st_d.rise = 1'b0;
        end else begin
            st_d.cnt  = st_q.cnt + HALF_ONE;
            st_d.rise = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q         <= '0;
            st_q.half    <= HALF_ONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ck_o   = st_q.ck;
    assign rise_o = st_q.rise;
    assign byp_o  = st_q.byp;
    assign bus_o  = st_q.bus;

    AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < st_q.half); // R1
    AST_RISE_IS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.rise && !st_q.byp) |-> (st_q.ck && !$past(st_q.ck))); // R8
    AST_HOLD_BETWEEN_EDGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.rise |-> ($stable(st_q.half) && $stable(st_q.bus) && $stable(st_q.byp))); // R8
    AST_TOGGLE_AT_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.byp && !$past(st_q.byp) && (st_q.ck != $past(st_q.ck)))
        |-> ($past(st_q.cnt) == $past(st_q.half) - HALF_ONE)); // R6

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
    import ccd_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DIV_W-1:0] div_i,
    input  logic             rate_zero_i,
    input  logic [2:0]       mode_i,
    input  logic [1:0]       width_i,
    input  logic             fb_sel_i,
    output logic             ck_o,
    output logic             ck_en_o,
    output logic             bypass_o,
    output logic             wide4_o,
    output logic             wide8_o,
    output logic             ddr_o,
    output logic             speed_o,
    output logic             hwfc_o,
    output logic             fb_sel_o
);
    logic [DIV_W-1:0] new_half;
    logic             new_byp;
    bus_cfg_t         new_bus;
    logic             core_ck, core_rise, core_byp;
    bus_cfg_t         core_bus;

    ccd_cfg_decode #(.DIV_W(DIV_W)) u_decode (
        .div_i       (div_i),
        .rate_zero_i (rate_zero_i),
        .mode_i      (mode_i),
        .width_i     (width_i),
        .fb_sel_i    (fb_sel_i),
        .half_o      (new_half),
        .byp_o       (new_byp),
        .bus_o       (new_bus)
    );

    ccd_toggle_core #(.DIV_W(DIV_W)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .new_half_i (new_half),
        .new_byp_i  (new_byp),
        .new_bus_i  (new_bus),
        .ck_o       (core_ck),
        .rise_o     (core_rise),
        .byp_o      (core_byp),
        .bus_o      (core_bus)
    );

    assign ck_o     = core_byp ? clk_i : core_ck;
    assign ck_en_o  = core_byp | core_rise;
    assign bypass_o = core_byp;
    assign wide4_o  = core_bus.wide4;
    assign wide8_o  = core_bus.wide8;
    assign ddr_o    = core_bus.ddr;
    assign speed_o  = core_bus.speed;
    assign hwfc_o   = core_bus.hwfc;
    assign fb_sel_o = core_bus.fbsel;

    AST_DDR_NEVER_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ddr_o |-> !bypass_o); // R3
    AST_ONE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wide4_o && wide8_o)); // R5

endmodule

// File: tb/card_clk_div_tb.sv
`timescale 1ns/1ps
module card_clk_div_tb_top;
    localparam int DIV_W = 10;
    localparam int MAXD  = (1 << DIV_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic             rate_zero = 1'b0;
    logic [2:0]       mode = '0;
    logic [1:0]       width = '0;
    logic             fb_sel = 1'b0;
    logic ck, en, byp, w4, w8, ddr, spd, hwfc, fbo;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk;

    card_clk_div #(.DIV_W(DIV_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .div_i(div), .rate_zero_i(rate_zero),
        .mode_i(mode), .width_i(width), .fb_sel_i(fb_sel),
        .ck_o(ck), .ck_en_o(en), .bypass_o(byp), .wide4_o(w4), .wide8_o(w8),
        .ddr_o(ddr), .speed_o(spd), .hwfc_o(hwfc), .fb_sel_o(fbo)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: age since the last rising edge
    bit m_started, m_byp, m_w4, m_w8, m_ddr, m_spd, m_hwfc, m_fb;
    int m_age, m_half;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 0; m_byp = 0; m_age = 0; m_half = 1;
            m_w4 = 0; m_w8 = 0; m_ddr = 0; m_spd = 0; m_hwfc = 0; m_fb = 0;
        end else if (!m_started || m_byp || m_age == 2 * m_half - 1) begin
            m_started = 1;
            m_age = 0;
            m_byp = 0;
            if (rate_zero)          m_half = MAXD;
            else if (div != 0)      m_half = int'(div);
            else begin
                m_half = 1;
                m_byp  = (mode != 3'd2);
            end
            m_w4 = (width == 2'd1); m_w8 = (width == 2'd2);
            m_ddr = (mode == 3'd2); m_spd = (mode >= 3'd3);
            m_hwfc = 1; m_fb = fb_sel;
        end else begin
            m_age++;
        end
    end

    always @(negedge clk) begin
        bit e_ck, e_en;
        e_ck = m_byp ? 1'b0 : (m_started && m_age < m_half);
        e_en = m_byp ? 1'b1 : (m_started && m_age == 0);
        chk(ck == e_ck,    "R6 ck_o",      ck,   e_ck);
        chk(en == e_en,    "R1 ck_en_o",   en,   e_en);
        chk(byp == m_byp,  "R2 bypass_o",  byp,  m_byp);
        chk(w4 == m_w4,    "R5 wide4_o",   w4,   m_w4);
        chk(w8 == m_w8,    "R5 wide8_o",   w8,   m_w8);
        chk(ddr == m_ddr,  "R7 ddr_o",     ddr,  m_ddr);
        chk(spd == m_spd,  "R7 speed_o",   spd,  m_spd);
        chk(hwfc == m_hwfc,"R7 hwfc_o",    hwfc, m_hwfc);
        chk(fbo == m_fb,   "R10 fb_sel_o", fbo,  m_fb);
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // waits for the next strobe (the take-up edge), then counts to the one after
    task automatic measure(output int p);
        do @(negedge clk); while (!en);
        p = 0;
        do begin @(negedge clk); p++; end while (!en);
    endtask

    initial begin
        int p;
        repeat (3) @(negedge clk);
        chk({ck, en, byp, w4, w8, ddr, spd, hwfc, fbo} == 9'd0, "R9 reset outputs",
            {ck, en, byp, w4, w8, ddr, spd, hwfc, fbo}, 0);
        div = 10'd3; width = 2'd1; mode = 3'd0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(hwfc == 1'b1, "R9 first take-up", hwfc, 1);

        foreach (div[i]) if (i == 0) begin end
        measure(p); chk(p == 6, "R1 period div3", p, 6);
        div = 10'd1; measure(p); chk(p == 2, "R1 period div1", p, 2);
        div = 10'd5; measure(p); chk(p == 10, "R1 period div5", p, 10);

        div = 10'd0; mode = 3'd1; measure(p);
        chk(p == 1, "R2 bypass strobe period", p, 1);
        chk(byp == 1'b1, "R2 bypass_o", byp, 1);
        @(posedge clk); #1;
        chk(ck == 1'b1, "R2 ck_o follows master high", ck, 1);
        @(negedge clk); #0.5;
        chk(ck == 1'b0, "R2 ck_o follows master low", ck, 0);

        mode = 3'd2; measure(p);
        chk(p == 2, "R3 ddr zero divider period", p, 2);
        chk(byp == 1'b0, "R3 no bypass in ddr", byp, 0);

        for (int w = 0; w < 4; w++) begin
            width = 2'(w); div = 10'd2; mode = 3'd0; measure(p);
            chk(w4 == (w == 1), "R5 wide4 code", w4, (w == 1));
            chk(w8 == (w == 2), "R5 wide8 code", w8, (w == 2));
        end

        for (int m = 0; m < 5; m++) begin
            mode = 3'(m); fb_sel = m[0]; measure(p);
            chk(ddr == (m == 2), "R7 ddr per mode", ddr, (m == 2));
            chk(spd == (m >= 3), "R7 speed per mode", spd, (m >= 3));
            chk(fbo == m[0], "R10 fb_sel applied", fbo, m[0]);
        end

        mode = 3'd0; width = 2'd0; div = 10'd4; measure(p); measure(p);
        width = 2'd1; div = 10'd2;
        @(negedge clk);
        chk(w4 == 1'b0, "R8 width held mid-period", w4, 0);
        chk(en == 1'b0, "R8 no early edge", en, 0);
        measure(p);
        chk(p == 4, "R8 new divider after edge", p, 4);
        chk(w4 == 1'b1, "R8 width taken at edge", w4, 1);

        rate_zero = 1'b1; div = 10'd3; measure(p);
        chk(p == 2 * MAXD, "R4 zero rate uses max divider", p, 2 * MAXD);
        rate_zero = 1'b0; measure(p);
        chk(p == 6, "R1 back from zero rate", p, 6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule